// File: doc/BRIEF.md
# Register-Indirect Address Generator

This block sits in front of a load/store unit and turns one register operand into the address used for a memory access. Each request carries a two-bit mode code, a two-bit operand-size code, the index of a base register and that register's current 32-bit content. The register content comes from a register file outside the block.

The block returns the resulting address, or the operand itself in direct mode, together with a flag that says whether memory is touched. For the two auto-modifying modes it also supplies a register write port: an enable, the register index and the new base value. Post-increment puts the old base on the address output and writes back the base plus the step. Pre-decrement subtracts the step first, then uses that result both as the address and as the written-back value.

Every result is registered, so it appears exactly one clock after the request. The block also flags a misaligned address and an illegal size code.

Top module: `reg_indirect_agu`

## Requirements
- R1: Mode code 00 (direct) returns the register content on `out_value` with `out_mem` low and no writeback.
- R2: Mode code 01 (indirect) returns the register content as the address with `out_mem` high, and the register is not written.
- R3: Mode code 10 (post-increment) returns the original register content as the address and writes back that content plus the step.
- R4: Mode code 11 (pre-decrement) returns the register content minus the step as the address and writes back that same value.
- R5: The step is 1 for size code 00 (byte), 2 for size code 01 (word) and 4 for size code 10 (longword).
- R6: Size code 11 raises `out_size_err` in every mode, uses a step of 0 and suppresses the writeback.
- R7: Address arithmetic is modulo 2^32. Adding past 0xFFFFFFFF wraps to low values, and subtracting below zero wraps to high values.
- R8: `out_valid` follows `in_valid` one clock later. `wb_en` is high only in that same cycle, and only for mode codes 10 and 11.
- R9: `out_misalign` is high for a memory access (modes 01, 10 and 11) when a word address is odd or a longword address is not a multiple of 4. Direct mode and byte accesses never raise it, and the writeback still happens on a misaligned access.
- R10: While `rst_n` is low, `out_valid` and `wb_en` are low.
- R11: `wb_idx` carries the register index of the request that caused the writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Addressing mode code |
| in_size | input | 2 | Operand size code |
| in_ridx | input | 4 | Base register index |
| in_rdata | input | 32 | Base register content |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_value | output | 32 | Effective address or direct operand |
| out_mem | output | 1 | Result is a memory address |
| out_misalign | output | 1 | Address misaligned for its size |
| out_size_err | output | 1 | Size code 11 was requested |
| wb_en | output | 1 | Base register write enable |
| wb_idx | output | 4 | Register index to write |
| wb_data | output | 32 | New base register value |

## Verification
Each mode is tried with every size code on a base value chosen so that the expected step stands out. This separates a wrong step table from a wrong mode decode, and post-increment's old-value address from pre-decrement's new-value address.

Bases near 0xFFFFFFFF and near zero show whether the carry and borrow wrap. Bases ending in 1, 2 and 3 separate the word and longword alignment rules, and show whether direct mode is kept out of the misalignment check.

Back-to-back requests followed by an idle cycle show that valid and writeback never outlast their request. A reset applied in the middle of a request shows that it clears them.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_INDIRECT = 2'b01,
    AM_POSTINC  = 2'b10,
    AM_PREDEC   = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_BAD   = 2'b11
  } op_size_e;

  typedef struct packed {
    logic [31:0] value;
    logic        mem;
    logic        misalign;
    logic        size_err;
    logic        wb;
    logic [31:0] wb_data;
  } agu_result_t;
endpackage

// File: rtl/agu_step.sv
module agu_step #(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] step,
  output logic              bad_size,
  output logic [1:0]        align_mask
);
  import agu_pkg::*;

  always_comb begin
    step       = '0;
    bad_size   = 1'b0;
    align_mask = 2'b00;
    case (op_size_e'(size))
      SZ_BYTE: step = ADDR_W'(1);
      SZ_WORD: begin
        step       = ADDR_W'(2);
        align_mask = 2'b01;
      end
      SZ_LONG: begin
        step       = ADDR_W'(4);
        align_mask = 2'b11;
      end
      default: bad_size = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc #(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step,
  input  logic              bad_size,
  input  logic [1:0]        align_mask,
  output logic [ADDR_W-1:0] value,
  output logic              mem,
  output logic              misalign,
  output logic              wb,
  output logic [ADDR_W-1:0] wb_data
);
  import agu_pkg::*;

  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] diff;

  assign sum  = base + step;
  assign diff = base - step;

  always_comb begin
    value   = base;
    mem     = 1'b0;
    wb      = 1'b0;
    wb_data = base;
    case (addr_mode_e'(mode))
      AM_DIRECT: ;
      AM_INDIRECT: mem = 1'b1;
      AM_POSTINC: begin
        mem     = 1'b1;
        wb      = ~bad_size;
        wb_data = sum;
      end
      default: begin
        mem     = 1'b1;
        value   = diff;
        wb      = ~bad_size;
        wb_data = diff;
      end
    endcase
  end

  assign misalign = mem & (|(value[1:0] & align_mask));
endmodule

// File: rtl/reg_indirect_agu.sv
module reg_indirect_agu #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_mode,
  input  logic [1:0]        in_size,
  input  logic [IDX_W-1:0]  in_ridx,
  input  logic [ADDR_W-1:0] in_rdata,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_value,
  output logic              out_mem,
  output logic              out_misalign,
  output logic              out_size_err,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [ADDR_W-1:0] wb_data
);
  logic [ADDR_W-1:0] step;
  logic              bad_size;
  logic [1:0]        align_mask;
  logic [ADDR_W-1:0] c_value;
  logic              c_mem;
  logic              c_misalign;
  logic              c_wb;
  logic [ADDR_W-1:0] c_wb_data;

  agu_step #(.ADDR_W(ADDR_W)) u_step (
    .size       (in_size),
    .step       (step),
    .bad_size   (bad_size),
    .align_mask (align_mask)
  );

  agu_calc #(.ADDR_W(ADDR_W)) u_calc (
    .mode       (in_mode),
    .base       (in_rdata),
    .step       (step),
    .bad_size   (bad_size),
    .align_mask (align_mask),
    .value      (c_value),
    .mem        (c_mem),
    .misalign   (c_misalign),
    .wb         (c_wb),
    .wb_data    (c_wb_data)
  );

  // control flags: reset, next state gated by in_valid
  logic ctl_valid_q, ctl_valid_d;
  logic ctl_wb_q, ctl_wb_d;
  logic ctl_mem_q, ctl_mem_d;
  logic ctl_mis_q, ctl_mis_d;
  logic ctl_err_q, ctl_err_d;

  always_comb begin
    ctl_valid_d = in_valid;
    ctl_wb_d    = in_valid & c_wb;
    ctl_mem_d   = in_valid & c_mem;
    ctl_mis_d   = in_valid & c_misalign;
    ctl_err_d   = in_valid & bad_size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_valid_q <= 1'b0;
      ctl_wb_q    <= 1'b0;
      ctl_mem_q   <= 1'b0;
      ctl_mis_q   <= 1'b0;
      ctl_err_q   <= 1'b0;
    end else begin
      ctl_valid_q <= ctl_valid_d;
      ctl_wb_q    <= ctl_wb_d;
      ctl_mem_q   <= ctl_mem_d;
      ctl_mis_q   <= ctl_mis_d;
      ctl_err_q   <= ctl_err_d;
    end
  end

  // data path: no reset, clock enable = in_valid
  logic [ADDR_W-1:0] val_q;
  logic [ADDR_W-1:0] wbd_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      val_q <= c_value;
      wbd_q <= c_wb_data;
      idx_q <= in_ridx;
    end
  end

  assign out_valid    = ctl_valid_q;
  assign out_value    = val_q;
  assign out_mem      = ctl_mem_q;
  assign out_misalign = ctl_mis_q;
  assign out_size_err = ctl_err_q;
  assign wb_en        = ctl_wb_q;
  assign wb_idx       = idx_q;
  assign wb_data      = wbd_q;
endmodule

// File: rtl/reg_indirect_agu_checker.sv
module reg_indirect_agu_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_mode,
  input logic [1:0]        in_size,
  input logic [IDX_W-1:0]  in_ridx,
  input logic [ADDR_W-1:0] in_rdata,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_value,
  input logic              out_mem,
  input logic              out_misalign,
  input logic              out_size_err,
  input logic              wb_en,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [ADDR_W-1:0] wb_data
);
  function automatic logic [ADDR_W-1:0] chk_step(input logic [1:0] s);
    case (s)
      2'b00:   return ADDR_W'(1);
      2'b01:   return ADDR_W'(2);
      2'b10:   return ADDR_W'(4);
      default: return '0;
    endcase
  endfunction

  assert_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'b00 |=> !out_mem && !wb_en && out_value == $past(in_rdata));

  assert_indirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'b01 |=> out_mem && !wb_en && out_value == $past(in_rdata));

  assert_postinc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'b10 && in_size != 2'b11 |=>
      wb_en && out_value == $past(in_rdata)
      && wb_data == $past(in_rdata) + chk_step($past(in_size)));

  assert_predec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 2'b11 && in_size != 2'b11 |=>
      wb_en && out_value == wb_data
      && wb_data == $past(in_rdata) - chk_step($past(in_size)));

  assert_bad_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size == 2'b11 |=> out_size_err && !wb_en);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wb_en);

  assert_wb_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid);

  assert_no_mis_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_misalign |-> out_mem);

  assert_wb_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wb_idx == $past(in_ridx));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R10: assert (!out_valid && !wb_en);
    end
  end
endmodule

bind reg_indirect_agu reg_indirect_agu_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_reg_indirect_agu.sv
module test_reg_indirect_agu;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_mode;
  logic [1:0]  in_size;
  logic [3:0]  in_ridx;
  logic [31:0] in_rdata;
  logic        out_valid;
  logic [31:0] out_value;
  logic        out_mem;
  logic        out_misalign;
  logic        out_size_err;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;

  int n_checks = 0;
  int n_fails  = 0;

  reg_indirect_agu i_reg_indirect_agu (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample just after the next posedge
  task automatic issue(input logic [1:0] m, input logic [1:0] s,
                       input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_size = s; in_ridx = idx; in_rdata = d;
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] stp(input logic [1:0] s);
    return (s == 2'b00) ? 32'd1 : (s == 2'b01) ? 32'd2 : (s == 2'b10) ? 32'd4 : 32'd0;
  endfunction

  task automatic t_reset;
    chk("R10 valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R10 wb_en in reset", {31'b0, wb_en}, 32'd0);
  endtask

  task automatic t_direct;
    for (int s = 0; s < 3; s++) begin
      issue(2'b00, 2'(s), 4'd3, 32'h1000_0003);
      chk("R1 value", out_value, 32'h1000_0003);
      chk("R1 mem", {31'b0, out_mem}, 32'd0);
      chk("R1 wb_en", {31'b0, wb_en}, 32'd0);
      chk("R9 direct no misalign", {31'b0, out_misalign}, 32'd0);
      chk("R8 valid", {31'b0, out_valid}, 32'd1);
    end
  endtask

  task automatic t_indirect;
    issue(2'b01, 2'b10, 4'd5, 32'h2000_0040);
    chk("R2 value", out_value, 32'h2000_0040);
    chk("R2 mem", {31'b0, out_mem}, 32'd1);
    chk("R2 wb_en", {31'b0, wb_en}, 32'd0);
  endtask

  task automatic t_postinc;
    for (int s = 0; s < 3; s++) begin
      issue(2'b10, 2'(s), 4'd7, 32'h0000_0100);
      chk("R3 addr", out_value, 32'h0000_0100);
      chk("R3 R5 wb_data", wb_data, 32'h0000_0100 + stp(2'(s)));
      chk("R8 wb_en", {31'b0, wb_en}, 32'd1);
      chk("R11 wb_idx", {28'b0, wb_idx}, 32'd7);
    end
  endtask

  task automatic t_predec;
    for (int s = 0; s < 3; s++) begin
      issue(2'b11, 2'(s), 4'd9, 32'h0000_0200);
      chk("R4 R5 addr", out_value, 32'h0000_0200 - stp(2'(s)));
      chk("R4 wb_data", wb_data, 32'h0000_0200 - stp(2'(s)));
      chk("R4 wb_en", {31'b0, wb_en}, 32'd1);
      chk("R11 wb_idx", {28'b0, wb_idx}, 32'd9);
    end
  endtask

  task automatic t_bad_size;
    issue(2'b10, 2'b11, 4'd2, 32'h0000_0300);
    chk("R6 err", {31'b0, out_size_err}, 32'd1);
    chk("R6 no wb", {31'b0, wb_en}, 32'd0);
    chk("R6 addr", out_value, 32'h0000_0300);
    issue(2'b11, 2'b11, 4'd2, 32'h0000_0300);
    chk("R6 predec addr", out_value, 32'h0000_0300);
    chk("R6 predec no wb", {31'b0, wb_en}, 32'd0);
    issue(2'b00, 2'b11, 4'd2, 32'h0000_0300);
    chk("R6 direct err", {31'b0, out_size_err}, 32'd1);
    issue(2'b01, 2'b10, 4'd2, 32'h0000_0300);
    chk("R6 legal no err", {31'b0, out_size_err}, 32'd0);
  endtask

  task automatic t_wrap;
    issue(2'b10, 2'b10, 4'd1, 32'hFFFF_FFFE);
    chk("R7 inc wrap", wb_data, 32'h0000_0002);
    issue(2'b11, 2'b01, 4'd1, 32'h0000_0001);
    chk("R7 dec wrap", out_value, 32'hFFFF_FFFF);
    issue(2'b10, 2'b00, 4'd1, 32'hFFFF_FFFF);
    chk("R7 byte wrap", wb_data, 32'h0000_0000);
  endtask

  task automatic t_misalign;
    issue(2'b01, 2'b01, 4'd4, 32'h0000_0011);
    chk("R9 word odd", {31'b0, out_misalign}, 32'd1);
    issue(2'b01, 2'b01, 4'd4, 32'h0000_0012);
    chk("R9 word even", {31'b0, out_misalign}, 32'd0);
    issue(2'b01, 2'b10, 4'd4, 32'h0000_0012);
    chk("R9 long by 2", {31'b0, out_misalign}, 32'd1);
    issue(2'b01, 2'b00, 4'd4, 32'h0000_0013);
    chk("R9 byte never", {31'b0, out_misalign}, 32'd0);
    issue(2'b10, 2'b10, 4'd4, 32'h0000_0016);
    chk("R9 postinc misaligned", {31'b0, out_misalign}, 32'd1);
    chk("R9 wb still", {31'b0, wb_en}, 32'd1);
    chk("R9 wb data", wb_data, 32'h0000_001A);
    issue(2'b11, 2'b10, 4'd4, 32'h0000_0018);
    chk("R9 predec aligned", {31'b0, out_misalign}, 32'd0);
  endtask

  task automatic t_idle;
    issue(2'b10, 2'b00, 4'd6, 32'h40);
    @(posedge clk); #2;
    chk("R8 valid drops", {31'b0, out_valid}, 32'd0);
    chk("R8 wb drops", {31'b0, wb_en}, 32'd0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'b10; in_size = 2'b10; in_ridx = 4'd8; in_rdata = 32'h80;
    @(posedge clk); #2;
    chk("R8 pre-reset valid", {31'b0, out_valid}, 32'd1);
    rst_n = 1'b0; #1;
    chk("R10 async valid", {31'b0, out_valid}, 32'd0);
    chk("R10 async wb", {31'b0, wb_en}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'b00; in_size = 2'b00;
    in_ridx = 4'd0; in_rdata = 32'd0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_direct();
    t_indirect();
    t_postinc();
    t_predec();
    t_bad_size();
    t_wrap();
    t_misalign();
    t_idle();
    t_reset_mid();
    t_indirect();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule